// File: doc/BRIEF.md
# Host Register Bridge for a Scan Controller

This block sits between a host processor bus and the core of a boundary-scan test controller. The host side uses a 5-bit address, a 16-bit data path (split into a write-data input and a read-data output), and separate read and write strobes, all sampled on the host clock. The core side runs on the test clock. The register file lives there, and it talks to the scan sequencer through plain command pulses and two small valid/ready streams.

Each host access is captured into a holding register. It is then handed to the test-clock domain with a toggle request and a two-flop synchronizer. The core answers with a toggle acknowledge, and read data comes back through the same handshake. The host therefore never waits on a fixed number of test-clock periods. It simply waits for `host_rdy` to rise again. The interrupt is computed in the core domain and synchronized to the host clock.

Back-pressure rules. The host strobe is a request that is only taken when `host_rdy` is high. A request made while `host_rdy` is low is dropped. On the core side, `core_rbuf_valid` data is taken only on a test-clock edge where `core_rbuf_ready` is high. `core_wbuf_valid` stays high until the sink raises `core_wbuf_ready`. A new host write to the write buffer replaces data that has not yet been taken.

Top module: `hreg_host_bridge`

## Requirements
- R1: After reset, `host_rdy` is 1 and `host_irq` is 0. Every mapped register reads 0, except the status register, which reads 0x0200 (the write buffer is empty).
- R2: A strobe (`host_wr` or `host_rd`) seen while `host_rdy` is 1 is accepted. `host_rdy` is 0 on the next host clock and stays 0 until the core acknowledges. Strobes seen while `host_rdy` is 0 are ignored. If both strobes are seen together, the write wins.
- R3: `host_rdata` changes only on the host clock edge where `host_rdy` returns to 1 after a read. It then holds the value of the addressed register.
- R4: The control register at address 0 is read/write and drives `core_ctrl`.
- R5: A write to a command register (address 2 drives `core_cmd0`, address 3 drives `core_cmd1`) updates that register. It also raises the matching `core_cmdN_pulse` for exactly one test clock. Both command registers read back.
- R6: Status register, address 1. Bits [7:0] are sticky and are set by `core_evt` pulses. Writing 1 to a bit clears it, and a set in the same cycle wins. Bit 8 is the read-buffer-full flag and bit 9 is the write-buffer-empty flag.
- R7: The read buffer, address 4, loads from the core stream when it is not full, which sets the full flag. A host read of address 4 returns the loaded word and clears the full flag.
- R8: A host write to address 5 stores the word, clears the empty flag and raises `core_wbuf_valid` with that word. A test-clock edge with `core_wbuf_ready` high sets the empty flag again.
- R9: `host_irq` is the OR of status bits [9:0] ANDed with control bits [9:0], delivered through a synchronizer.
- R10: Addresses 24 to 31 read as 0. Writes to them change no register.
- R11: Addresses 6 to 23 are general-purpose read/write registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Host clock |
| hrst_n | input | 1 | Host-domain reset, active low |
| host_addr | input | 5 | Register address |
| host_wdata | input | 16 | Write data |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_rdata | output | 16 | Read data, valid when `host_rdy` rises after a read |
| host_rdy | output | 1 | Ready for a new access |
| host_irq | output | 1 | Interrupt request |
| tclk | input | 1 | Test clock |
| trst_n | input | 1 | Test-domain reset, active low |
| core_evt | input | 8 | Status event pulses from the core |
| core_ctrl | output | 16 | Control register value |
| core_cmd0 | output | 16 | First command register |
| core_cmd0_pulse | output | 1 | One-cycle strobe on a first-command write |
| core_cmd1 | output | 16 | Second command register |
| core_cmd1_pulse | output | 1 | One-cycle strobe on a second-command write |
| core_rbuf_valid | input | 1 | Read-buffer load request |
| core_rbuf_data | input | 16 | Read-buffer load data |
| core_rbuf_ready | output | 1 | Read buffer can take a word |
| core_wbuf_valid | output | 1 | Write buffer holds a word |
| core_wbuf_data | output | 16 | Write-buffer word |
| core_wbuf_ready | input | 1 | Core takes the write-buffer word |

## Verification
The assertions check the cycle-level handshake rules on every edge of their clock domain: that `host_rdy` drops after an accepted strobe, that `host_rdata` never moves while the bridge is idle, that a full read buffer stops taking data, that the write-buffer valid holds under back-pressure, and that command strobes last one cycle. The register semantics can only be shown by the bench's scenarios, because they span both clocks and many cycles. These are the values read back, W1C status with set priority, buffer flag changes, masked interrupts, dropped busy strobes and the silence of unmapped addresses.

// File: rtl/hreg_pkg.sv
package hreg_pkg;
  localparam int unsigned HR_CTRL = 0;
  localparam int unsigned HR_STAT = 1;
  localparam int unsigned HR_CMD0 = 2;
  localparam int unsigned HR_CMD1 = 3;
  localparam int unsigned HR_RBUF = 4;
  localparam int unsigned HR_WBUF = 5;
  localparam int unsigned HR_GP_BASE = 6;
endpackage

// File: rtl/hreg_sync.sv
module hreg_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/hreg_host_side.sv
module hreg_host_side #(
  parameter int unsigned AW = 5,
  parameter int unsigned DW = 16
) (
  input  logic          hclk,
  input  logic          hrst_n,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  input  logic          host_wr,
  input  logic          host_rd,
  output logic [DW-1:0] host_rdata,
  output logic          host_rdy,
  output logic          host_irq,
  output logic          req_tgl,
  output logic          acc_wr,
  output logic [AW-1:0] acc_addr,
  output logic [DW-1:0] acc_wdata,
  input  logic          ack_tgl_t,
  input  logic [DW-1:0] rd_hold_t,
  input  logic          irq_t
);
  logic pend;
  logic ack_s;

  hreg_sync #(.W(1)) u_ack_sync (.clk(hclk), .rst_n(hrst_n), .d(ack_tgl_t), .q(ack_s));
  hreg_sync #(.W(1)) u_irq_sync (.clk(hclk), .rst_n(hrst_n), .d(irq_t), .q(host_irq));

  always_ff @(posedge hclk or negedge hrst_n) begin
    if (!hrst_n) begin
      pend       <= 1'b0;
      req_tgl    <= 1'b0;
      acc_wr     <= 1'b0;
      acc_addr   <= '0;
      acc_wdata  <= '0;
      host_rdata <= '0;
    end else if (!pend && (host_wr || host_rd)) begin
      pend      <= 1'b1;
      req_tgl   <= ~req_tgl;
      acc_wr    <= host_wr;
      acc_addr  <= host_addr;
      acc_wdata <= host_wdata;
    end else if (pend && (ack_s == req_tgl)) begin
      pend <= 1'b0;
      if (!acc_wr) host_rdata <= rd_hold_t;
    end
  end

  assign host_rdy = ~pend;
endmodule

// File: rtl/hreg_core_regs.sv
module hreg_core_regs
  import hreg_pkg::*;
#(
  parameter int unsigned AW   = 5,
  parameter int unsigned DW   = 16,
  parameter int unsigned NREG = 24,
  parameter int unsigned EW   = 8
) (
  input  logic          tclk,
  input  logic          trst_n,
  input  logic          req_tgl_h,
  input  logic          acc_wr,
  input  logic [AW-1:0] acc_addr,
  input  logic [DW-1:0] acc_wdata,
  output logic          ack_tgl,
  output logic [DW-1:0] rd_hold,
  output logic          irq,
  input  logic [EW-1:0] core_evt,
  output logic [DW-1:0] core_ctrl,
  output logic [DW-1:0] core_cmd0,
  output logic          core_cmd0_pulse,
  output logic [DW-1:0] core_cmd1,
  output logic          core_cmd1_pulse,
  input  logic          core_rbuf_valid,
  input  logic [DW-1:0] core_rbuf_data,
  output logic          core_rbuf_ready,
  output logic          core_wbuf_valid,
  output logic [DW-1:0] core_wbuf_data,
  input  logic          core_wbuf_ready
);
  localparam int unsigned NGP = NREG - HR_GP_BASE;
  localparam int unsigned GW  = (NGP > 1) ? $clog2(NGP) : 1;
  localparam int unsigned SW  = EW + 2;

  logic          req_s, req_seen, fire, wr_fire, rd_fire;
  logic [EW-1:0] stat_q;
  logic          rbuf_full, wbuf_empty;
  logic [DW-1:0] rbuf_q, rmux;
  logic [SW-1:0] stat_vec;
  logic [DW-1:0] gp_q [NGP];
  logic [GW-1:0] gidx;

  hreg_sync #(.W(1)) u_req_sync (.clk(tclk), .rst_n(trst_n), .d(req_tgl_h), .q(req_s));

  assign fire    = req_s ^ req_seen;
  assign wr_fire = fire & acc_wr;
  assign rd_fire = fire & ~acc_wr;

  function automatic logic hit(input logic [AW-1:0] a, input int unsigned idx);
    return a == AW'(idx);
  endfunction

  assign stat_vec = {wbuf_empty, rbuf_full, stat_q};

  always_ff @(posedge tclk or negedge trst_n) begin
    if (!trst_n) begin
      req_seen        <= 1'b0;
      ack_tgl         <= 1'b0;
      rd_hold         <= '0;
      irq             <= 1'b0;
      core_ctrl       <= '0;
      stat_q          <= '0;
      core_cmd0       <= '0;
      core_cmd1       <= '0;
      core_cmd0_pulse <= 1'b0;
      core_cmd1_pulse <= 1'b0;
      rbuf_q          <= '0;
      rbuf_full       <= 1'b0;
      core_wbuf_data  <= '0;
      wbuf_empty      <= 1'b1;
    end else begin
      req_seen <= req_s;
      if (fire) ack_tgl <= ~ack_tgl;
      if (rd_fire) rd_hold <= rmux;
      irq <= |(stat_vec & core_ctrl[SW-1:0]);

      if (wr_fire && hit(acc_addr, HR_CTRL)) core_ctrl <= acc_wdata;

      stat_q <= (stat_q & ~((wr_fire && hit(acc_addr, HR_STAT)) ? acc_wdata[EW-1:0] : '0))
                | core_evt;

      core_cmd0_pulse <= wr_fire && hit(acc_addr, HR_CMD0);
      core_cmd1_pulse <= wr_fire && hit(acc_addr, HR_CMD1);
      if (wr_fire && hit(acc_addr, HR_CMD0)) core_cmd0 <= acc_wdata;
      if (wr_fire && hit(acc_addr, HR_CMD1)) core_cmd1 <= acc_wdata;

      if (core_rbuf_valid && !rbuf_full) begin
        rbuf_q    <= core_rbuf_data;
        rbuf_full <= 1'b1;
      end else if (rd_fire && hit(acc_addr, HR_RBUF)) begin
        rbuf_full <= 1'b0;
      end

      if (wr_fire && hit(acc_addr, HR_WBUF)) begin
        core_wbuf_data <= acc_wdata;
        wbuf_empty     <= 1'b0;
      end else if (!wbuf_empty && core_wbuf_ready) begin
        wbuf_empty <= 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NGP; g++) begin : g_gp
    always_ff @(posedge tclk or negedge trst_n) begin
      if (!trst_n) gp_q[g] <= '0;
      else if (wr_fire && hit(acc_addr, HR_GP_BASE + g)) gp_q[g] <= acc_wdata;
    end
  end

  assign gidx = GW'(acc_addr - AW'(HR_GP_BASE));

  always_comb begin
    rmux = '0;
    if (hit(acc_addr, HR_CTRL))      rmux = core_ctrl;
    else if (hit(acc_addr, HR_STAT)) rmux = DW'(stat_vec);
    else if (hit(acc_addr, HR_CMD0)) rmux = core_cmd0;
    else if (hit(acc_addr, HR_CMD1)) rmux = core_cmd1;
    else if (hit(acc_addr, HR_RBUF)) rmux = rbuf_q;
    else if (hit(acc_addr, HR_WBUF)) rmux = core_wbuf_data;
    else if (acc_addr >= AW'(HR_GP_BASE) && acc_addr < AW'(NREG)) rmux = gp_q[gidx];
  end

  assign core_rbuf_ready = ~rbuf_full;
  assign core_wbuf_valid = ~wbuf_empty;
endmodule

// File: rtl/hreg_host_bridge.sv
module hreg_host_bridge #(
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned NUM_REGS = 24,
  parameter int unsigned EVT_W    = 8
) (
  input  logic              hclk,
  input  logic              hrst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              host_wr,
  input  logic              host_rd,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_rdy,
  output logic              host_irq,
  input  logic              tclk,
  input  logic              trst_n,
  input  logic [EVT_W-1:0]  core_evt,
  output logic [DATA_W-1:0] core_ctrl,
  output logic [DATA_W-1:0] core_cmd0,
  output logic              core_cmd0_pulse,
  output logic [DATA_W-1:0] core_cmd1,
  output logic              core_cmd1_pulse,
  input  logic              core_rbuf_valid,
  input  logic [DATA_W-1:0] core_rbuf_data,
  output logic              core_rbuf_ready,
  output logic              core_wbuf_valid,
  output logic [DATA_W-1:0] core_wbuf_data,
  input  logic              core_wbuf_ready
);
  logic              req_tgl, acc_wr, ack_tgl, irq_t;
  logic [ADDR_W-1:0] acc_addr;
  logic [DATA_W-1:0] acc_wdata, rd_hold;

  hreg_host_side #(.AW(ADDR_W), .DW(DATA_W)) u_host (
    .hclk(hclk), .hrst_n(hrst_n), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata), .host_rdy(host_rdy),
    .host_irq(host_irq), .req_tgl(req_tgl), .acc_wr(acc_wr), .acc_addr(acc_addr),
    .acc_wdata(acc_wdata), .ack_tgl_t(ack_tgl), .rd_hold_t(rd_hold), .irq_t(irq_t)
  );

  hreg_core_regs #(.AW(ADDR_W), .DW(DATA_W), .NREG(NUM_REGS), .EW(EVT_W)) u_core (
    .tclk(tclk), .trst_n(trst_n), .req_tgl_h(req_tgl), .acc_wr(acc_wr),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .ack_tgl(ack_tgl), .rd_hold(rd_hold),
    .irq(irq_t), .core_evt(core_evt), .core_ctrl(core_ctrl), .core_cmd0(core_cmd0),
    .core_cmd0_pulse(core_cmd0_pulse), .core_cmd1(core_cmd1),
    .core_cmd1_pulse(core_cmd1_pulse), .core_rbuf_valid(core_rbuf_valid),
    .core_rbuf_data(core_rbuf_data), .core_rbuf_ready(core_rbuf_ready),
    .core_wbuf_valid(core_wbuf_valid), .core_wbuf_data(core_wbuf_data),
    .core_wbuf_ready(core_wbuf_ready)
  );
endmodule

// File: rtl/hreg_checker.sv
module hreg_checker #(
  parameter int unsigned DW = 16
) (
  input logic          hclk,
  input logic          hrst_n,
  input logic          tclk,
  input logic          trst_n,
  input logic          host_wr,
  input logic          host_rd,
  input logic          host_rdy,
  input logic [DW-1:0] host_rdata,
  input logic          core_rbuf_valid,
  input logic          core_rbuf_ready,
  input logic          core_wbuf_valid,
  input logic          core_wbuf_ready,
  input logic          core_cmd0_pulse,
  input logic          core_cmd1_pulse
);
  AST_ACCEPT_DROPS_RDY: assert property (@(posedge hclk) disable iff (!hrst_n)
    (host_rdy && (host_wr || host_rd)) |=> !host_rdy); // R2
  AST_RDATA_HOLDS_IDLE: assert property (@(posedge hclk) disable iff (!hrst_n)
    host_rdy |=> $stable(host_rdata)); // R3
  AST_RBUF_FILLS: assert property (@(posedge tclk) disable iff (!trst_n)
    (core_rbuf_valid && core_rbuf_ready) |=> !core_rbuf_ready); // R7
  AST_WBUF_VALID_HOLDS: assert property (@(posedge tclk) disable iff (!trst_n)
    (core_wbuf_valid && !core_wbuf_ready) |=> core_wbuf_valid); // R8
  AST_CMD0_ONE_CYCLE: assert property (@(posedge tclk) disable iff (!trst_n)
    core_cmd0_pulse |=> !core_cmd0_pulse); // R5
  AST_CMD1_ONE_CYCLE: assert property (@(posedge tclk) disable iff (!trst_n)
    core_cmd1_pulse |=> !core_cmd1_pulse); // R5
endmodule

bind hreg_host_bridge hreg_checker #(.DW(DATA_W)) u_hreg_checker (
  .hclk(hclk), .hrst_n(hrst_n), .tclk(tclk), .trst_n(trst_n),
  .host_wr(host_wr), .host_rd(host_rd), .host_rdy(host_rdy), .host_rdata(host_rdata),
  .core_rbuf_valid(core_rbuf_valid), .core_rbuf_ready(core_rbuf_ready),
  .core_wbuf_valid(core_wbuf_valid), .core_wbuf_ready(core_wbuf_ready),
  .core_cmd0_pulse(core_cmd0_pulse), .core_cmd1_pulse(core_cmd1_pulse)
);

// File: tb/hreg_host_bridge_bench.sv
module hreg_host_bridge_bench;
  logic hclk = 1'b0, tclk = 1'b0, hrst_n = 1'b0, trst_n = 1'b0;
  logic [4:0]  host_addr = '0;
  logic [15:0] host_wdata = '0, host_rdata, core_ctrl, core_cmd0, core_cmd1;
  logic [15:0] core_rbuf_data = '0, core_wbuf_data;
  logic host_wr = 0, host_rd = 0, host_rdy, host_irq;
  logic [7:0] core_evt = '0;
  logic core_cmd0_pulse, core_cmd1_pulse, core_rbuf_valid = 0, core_rbuf_ready;
  logic core_wbuf_valid, core_wbuf_ready = 0;
  int n_cmp = 0, n_bad = 0, cmd0_cnt = 0;
  logic [15:0] cmd0_seen = '0, rv;

  always #2 hclk = ~hclk;
  always #7 tclk = ~tclk;

  hreg_host_bridge u_hreg_host_bridge (.*);

  always @(posedge tclk) if (core_cmd0_pulse) begin cmd0_cnt++; cmd0_seen = core_cmd0; end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_rdy();
    @(negedge hclk);
    while (!host_rdy) @(negedge hclk);
  endtask

  task automatic hwrite(input logic [4:0] a, input logic [15:0] d);
    wait_rdy();
    host_addr = a; host_wdata = d; host_wr = 1;
    @(negedge hclk);
    host_wr = 0;
    wait_rdy();
  endtask

  task automatic hread(input logic [4:0] a, output logic [15:0] d);
    wait_rdy();
    host_addr = a; host_rd = 1;
    @(negedge hclk);
    host_rd = 0;
    wait_rdy();
    d = host_rdata;
  endtask

  task automatic t_reset();
    chk("R1 rdy", 16'(host_rdy), 16'h1);
    chk("R1 irq", 16'(host_irq), 16'h0);
    hread(0, rv); chk("R1 ctrl", rv, 16'h0000);
    hread(1, rv); chk("R1 stat", rv, 16'h0200);
    hread(4, rv); chk("R1 rbuf", rv, 16'h0000);
    hread(9, rv); chk("R1 gp", rv, 16'h0000);
  endtask

  task automatic t_handshake();
    wait_rdy();
    host_addr = 5'd7; host_wdata = 16'h1111; host_wr = 1;
    @(negedge hclk);
    host_wr = 0;
    chk("R2 rdy low after accept", 16'(host_rdy), 16'h0);
    host_addr = 5'd8; host_wdata = 16'h2222; host_wr = 1;
    @(negedge hclk);
    host_wr = 0;
    wait_rdy();
    hread(7, rv); chk("R2 first write", rv, 16'h1111);
    hread(8, rv); chk("R2 busy write dropped", rv, 16'h0000);
    wait_rdy();
    host_addr = 5'd10; host_wdata = 16'h3333; host_wr = 1; host_rd = 1;
    @(negedge hclk);
    host_wr = 0; host_rd = 0;
    wait_rdy();
    chk("R3 rdata unchanged by write", host_rdata, 16'h0000);
    hread(10, rv); chk("R2 write wins over read", rv, 16'h3333);
  endtask

  task automatic t_regs();
    hwrite(0, 16'hA400); chk("R4 core_ctrl", core_ctrl, 16'hA400);
    hread(0, rv); chk("R4 ctrl readback", rv, 16'hA400);
    hwrite(0, 16'h0000);
    for (int i = 6; i < 24; i++) hwrite(5'(i), 16'(16'h5000 + i));
    for (int i = 6; i < 24; i++) begin
      hread(5'(i), rv); chk("R11 gp readback", rv, 16'(16'h5000 + i));
    end
    hwrite(5'd30, 16'hFFFF);
    hwrite(5'd24, 16'hFFFF);
    hread(5'd30, rv); chk("R10 unmapped reads zero", rv, 16'h0000);
    hread(5'd24, rv); chk("R10 unmapped reads zero", rv, 16'h0000);
    hread(5'd6, rv);  chk("R10 gp untouched", rv, 16'h5006);
    hread(5'd23, rv); chk("R10 gp untouched", rv, 16'h5017);
    hread(5'd0, rv);  chk("R10 ctrl untouched", rv, 16'h0000);
  endtask

  task automatic t_cmd();
    int base;
    base = cmd0_cnt;
    hwrite(2, 16'h1234);
    repeat (6) @(negedge tclk);
    chk("R5 cmd0 pulse count", 16'(cmd0_cnt - base), 16'h1);
    chk("R5 cmd0 value at pulse", cmd0_seen, 16'h1234);
    hwrite(3, 16'hCAFE);
    chk("R5 cmd1 port", core_cmd1, 16'hCAFE);
    hread(3, rv); chk("R5 cmd1 readback", rv, 16'hCAFE);
    hread(2, rv); chk("R5 cmd0 readback", rv, 16'h1234);
  endtask

  task automatic t_status();
    @(negedge tclk); core_evt = 8'h05;
    @(negedge tclk); core_evt = 8'h00;
    hread(1, rv); chk("R6 events set", rv, 16'h0205);
    hwrite(1, 16'h0001);
    hread(1, rv); chk("R6 w1c clears bit0", rv, 16'h0204);
    hwrite(1, 16'h03FF);
    hread(1, rv); chk("R6 w1c clears all, flags unaffected", rv, 16'h0200);
  endtask

  task automatic t_rbuf();
    @(negedge tclk);
    chk("R7 ready when empty", 16'(core_rbuf_ready), 16'h1);
    core_rbuf_valid = 1; core_rbuf_data = 16'h9ABC;
    @(negedge tclk);
    core_rbuf_data = 16'h7777;
    @(negedge tclk);
    core_rbuf_valid = 0;
    chk("R7 not ready when full", 16'(core_rbuf_ready), 16'h0);
    hread(1, rv); chk("R7 full flag set", rv, 16'h0300);
    hread(4, rv); chk("R7 rbuf data", rv, 16'h9ABC);
    hread(1, rv); chk("R7 full flag cleared by read", rv, 16'h0200);
  endtask

  task automatic t_wbuf();
    hwrite(5, 16'hBEEF);
    @(negedge tclk);
    chk("R8 wbuf valid", 16'(core_wbuf_valid), 16'h1);
    chk("R8 wbuf data", core_wbuf_data, 16'hBEEF);
    hread(1, rv); chk("R8 empty flag cleared", rv, 16'h0000);
    @(negedge tclk); core_wbuf_ready = 1;
    @(negedge tclk); core_wbuf_ready = 0;
    chk("R8 drained", 16'(core_wbuf_valid), 16'h0);
    hread(1, rv); chk("R8 empty flag set", rv, 16'h0200);
  endtask

  task automatic t_irq();
    hwrite(0, 16'h0100);
    repeat (10) @(negedge hclk);
    chk("R9 masked: rbuf empty", 16'(host_irq), 16'h0);
    hwrite(0, 16'h0200);
    repeat (10) @(negedge hclk);
    chk("R9 wbuf empty enabled", 16'(host_irq), 16'h1);
    hwrite(0, 16'h0008);
    repeat (10) @(negedge hclk);
    chk("R9 event bit3 clear", 16'(host_irq), 16'h0);
    @(negedge tclk); core_evt = 8'h08;
    @(negedge tclk); core_evt = 8'h00;
    repeat (10) @(negedge hclk);
    chk("R9 event bit3 raises irq", 16'(host_irq), 16'h1);
    hwrite(1, 16'h0008);
    repeat (10) @(negedge hclk);
    chk("R9 irq drops after w1c", 16'(host_irq), 16'h0);
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge tclk);
    hrst_n = 1; trst_n = 1;
    repeat (3) @(negedge hclk);
    t_reset();
    t_handshake();
    t_regs();
    t_cmd();
    t_status();
    t_rbuf();
    t_wbuf();
    t_irq();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule